// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects eight interrupt request lines from peripherals and presents one interrupt line to the processor. Three 8-bit registers hold its state. The request register shows which lines are asking for service. The in-service register shows which lines the processor is handling now. The mask register blocks lines one by one. A fixed-priority resolver picks a winner. Line 0 has the highest priority and line 7 the lowest. A request raises the processor interrupt only when no line of equal or higher priority is in service.

The processor answers with two acknowledge pulses. On the first pulse the winning request moves into the in-service register. On the second pulse the controller drives an 8-bit type onto its read-data bus. The top five bits of the type come from the configured vector base and the low three bits are the number of the winning line. Software configures the block through a byte-wide host port: a chip select, read and write strobes, and one address bit. A setup sequence of two to four words must come first. After setup, the same port writes the mask, issues end-of-interrupt commands and reads status.

The host port has no back-pressure. Every strobe is accepted as it arrives, and read data is valid for as long as the read strobe is held.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, `cpu_irq` is low, the block is not configured, the request and in-service registers are empty, and the mask is 8'hFF.
- R2: A write with `bus_addr`=0 and data bit 4 = 1 is setup word 1, accepted in any state. Bit 3 selects level sensing (1) or edge sensing (0), bit 1 = 1 means single mode and bit 0 = 1 means a fourth setup word follows. The write clears the mask, request and in-service registers. It also re-arms edge sensing, so a line that is already high must fall and rise again before it is latched.
- R3: The next write with `bus_addr`=1 stores the vector base (bits 7:3). When bit 1 of setup word 1 was 0, one more `bus_addr`=1 word is consumed. When bit 0 was 1, a further `bus_addr`=1 word is consumed after that. `cpu_irq` stays low until the sequence is complete.
- R4: Once configured, a write with `bus_addr`=1 loads the mask. A 1 in bit n blocks line n and a 0 lets it through.
- R5: While `bus_sel_n` and `bus_rd_n` are both low, `bus_rdata` returns the request register when `bus_addr`=0 and the mask when `bus_addr`=1, in the same cycle, with `bus_rdata_en` high.
- R6: In edge mode, a rising edge on a line latches its request bit. The bit clears if the line falls before it is acknowledged.
- R7: In level mode, the request bit follows the line, including right after an acknowledge while the line is still high.
- R8: `cpu_irq` is high exactly when the block is configured and the lowest-numbered unmasked pending line has a lower number than every in-service line.
- R9: On the first acknowledge pulse, the winning line's request bit clears and its in-service bit sets.
- R10: While the second acknowledge pulse is held, `bus_rdata` carries base[7:3] followed by the 3-bit winning line number, with `bus_rdata_en` high.
- R11: A first acknowledge pulse that arrives while `cpu_irq` is low changes no in-service bit, and the type that follows carries line number 7.
- R12: A configured write with `bus_addr`=0 and data 8'h20 clears the lowest-numbered in-service bit. Other writes with `bus_addr`=0 and bit 4 = 0 have no effect.
- R13: A write takes effect only while `bus_sel_n` is low, and only once for each strobe, however long the strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_n | input | 1 | Active-low chip select |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_addr | input | 1 | Register address bit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data or interrupt type |
| bus_rdata_en | output | 1 | High when bus_rdata carries valid data |
| irq_in | input | 8 | Request lines, line 0 has the highest priority |
| cpu_irq | output | 1 | Interrupt to the processor |
| ack_n | input | 1 | Active-low acknowledge from the processor |

## Verification
A write strobe, a change on a request line and an acknowledge pulse are each registered on the first rising edge that sees them. Their effects therefore show on `cpu_irq` and `bus_rdata` one cycle later. A read is combinational, and its value appears in the same cycle as the strobe. The interrupt type shows on the cycle after the edge that registers the second acknowledge. The bench drives every input at the falling edge of the clock and compares all outputs against a behavioural model 1 ns after the next falling edge. Its directed checks wait out the full register path before they sample.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_CHAIN,
    CFG_EXT,
    CFG_RUN
  } cfg_state_e;

  localparam int unsigned SEL_BIT  = 4;
  localparam int unsigned TRIG_BIT = 3;
  localparam int unsigned SOLO_BIT = 1;
  localparam int unsigned EXT_BIT  = 0;
  localparam logic [7:0]  EOI_CODE = 8'h20;
endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
  import pic8_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic          level_mode,
  output logic [DW-1:0] base,
  output logic [N-1:0]  mask,
  output logic          ready,
  output logic          init_pulse,
  output logic          eoi_pulse
);
  cfg_state_e st;
  logic wr_act, wr_q, wr_fire, solo, ext;

  assign wr_act     = ~sel_n & ~wr_n;
  assign wr_fire    = wr_act & ~wr_q;
  assign init_pulse = wr_fire & ~addr & wdata[SEL_BIT];
  assign eoi_pulse  = wr_fire & ~addr & (st == CFG_RUN) & (wdata == EOI_CODE);
  assign ready      = (st == CFG_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= CFG_IDLE;
      wr_q       <= 1'b0;
      mask       <= '1;
      base       <= '0;
      level_mode <= 1'b0;
      solo       <= 1'b0;
      ext        <= 1'b0;
    end else begin
      wr_q <= wr_act;
      if (init_pulse) begin
        st         <= CFG_BASE;
        mask       <= '0;
        level_mode <= wdata[TRIG_BIT];
        solo       <= wdata[SOLO_BIT];
        ext        <= wdata[EXT_BIT];
      end else if (wr_fire && addr) begin
        case (st)
          CFG_BASE: begin
            base <= {wdata[DW-1:IW], {IW{1'b0}}};
            if (!solo)    st <= CFG_CHAIN;
            else if (ext) st <= CFG_EXT;
            else          st <= CFG_RUN;
          end
          CFG_CHAIN: st <= ext ? CFG_EXT : CFG_RUN;
          CFG_EXT:   st <= CFG_RUN;
          CFG_RUN:   mask <= wdata[N-1:0];
          default:   st <= st;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic8_req_latch.sv
module pic8_req_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic         level_mode,
  input  logic         init_pulse,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] req
);
  logic [N-1:0] prev;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev[g] <= 1'b1;
        req[g]  <= 1'b0;
      end else if (init_pulse) begin
        prev[g] <= 1'b1;
        req[g]  <= 1'b0;
      end else begin
        prev[g] <= lines[g];
        if (level_mode)
          req[g] <= lines[g] & ~ack_clr[g];
        else
          req[g] <= (req[g] | (lines[g] & ~prev[g])) & lines[g] & ~ack_clr[g];
      end
    end
  end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          ready,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  svc,
  output logic          int_req,
  output logic [IW-1:0] win_idx
);
  logic [N-1:0]  pend;
  logic          p_any, s_any;
  logic [IW-1:0] s_idx;

  always_comb begin
    pend    = req & ~mask;
    p_any   = |pend;
    s_any   = |svc;
    win_idx = '0;
    s_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) win_idx = IW'(i);
      if (svc[i])  s_idx   = IW'(i);
    end
    int_req = ready & p_any & (~s_any | (win_idx < s_idx));
  end
endmodule

// File: rtl/pic8_svc.sv
module pic8_svc #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_n,
  input  logic          init_pulse,
  input  logic          eoi_pulse,
  input  logic          int_req,
  input  logic [IW-1:0] win_idx,
  output logic [N-1:0]  svc,
  output logic [N-1:0]  ack_clr,
  output logic [IW-1:0] vec,
  output logic          type_drive
);
  logic ack_act, ack_q, ack_fire, phase, drv;
  logic [N-1:0] eoi_bit;

  assign ack_act    = ~ack_n;
  assign ack_fire   = ack_act & ~ack_q;
  assign ack_clr    = (ack_fire & ~phase & int_req) ? (N'(1) << win_idx) : '0;
  assign eoi_bit    = svc & (~svc + N'(1));
  assign type_drive = drv & ack_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      phase <= 1'b0;
      drv   <= 1'b0;
      vec   <= '0;
      svc   <= '0;
    end else begin
      ack_q <= ack_act;
      if (init_pulse) begin
        phase <= 1'b0;
        drv   <= 1'b0;
        vec   <= '0;
        svc   <= '0;
      end else begin
        svc <= (svc | ack_clr) & ~(eoi_pulse ? eoi_bit : '0);
        if (ack_fire && !phase) begin
          phase <= 1'b1;
          vec   <= int_req ? win_idx : '1;
        end else if (ack_fire && phase) begin
          phase <= 1'b0;
          drv   <= 1'b1;
        end else if (!ack_act) begin
          drv <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rdata_en,
  input  logic [N-1:0]  irq_in,
  output logic          cpu_irq,
  input  logic          ack_n
);
  logic          level_w, ready_w, init_w, eoi_w, drive_w, rd_act;
  logic [DW-1:0] base_w;
  logic [N-1:0]  mask_w, irr_w, isr_w, ack_clr_w;
  logic [IW-1:0] win_w, vec_w;

  pic8_cfg #(.N(N), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .sel_n(bus_sel_n), .wr_n(bus_wr_n),
    .addr(bus_addr), .wdata(bus_wdata), .level_mode(level_w), .base(base_w),
    .mask(mask_w), .ready(ready_w), .init_pulse(init_w), .eoi_pulse(eoi_w)
  );

  pic8_req_latch #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .level_mode(level_w),
    .init_pulse(init_w), .ack_clr(ack_clr_w), .req(irr_w)
  );

  pic8_prio #(.N(N)) u_prio (
    .ready(ready_w), .req(irr_w), .mask(mask_w), .svc(isr_w),
    .int_req(cpu_irq), .win_idx(win_w)
  );

  pic8_svc #(.N(N)) u_svc (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .init_pulse(init_w),
    .eoi_pulse(eoi_w), .int_req(cpu_irq), .win_idx(win_w), .svc(isr_w),
    .ack_clr(ack_clr_w), .vec(vec_w), .type_drive(drive_w)
  );

  assign rd_act       = ~bus_sel_n & ~bus_rd_n;
  assign bus_rdata_en = drive_w | rd_act;

  always_comb begin
    if (drive_w)      bus_rdata = {base_w[DW-1:IW], vec_w};
    else if (rd_act)  bus_rdata = bus_addr ? DW'(mask_w) : DW'(irr_w);
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/pic8_chk.sv
module pic8_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cpu_irq,
  input logic         ready,
  input logic [N-1:0] irr,
  input logic [N-1:0] mask,
  input logic [N-1:0] isr,
  input logic         init_pulse,
  input logic         eoi_pulse,
  input logic [N-1:0] ack_clr,
  input logic         type_drive,
  input logic [7:0]   dout,
  input logic [7:0]   base
);
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ((irr & ~mask) != '0)); // R8
  AST_IRQ_QUIET_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !cpu_irq); // R3
  AST_MASK_OPEN_ON_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (mask == '0)); // R2
  AST_ACK_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr != '0) |-> ((ack_clr & irr) != '0)); // R9
  AST_ACK_GROWS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_clr != '0) && !eoi_pulse && !init_pulse)
      |=> ($countones(isr) == $past($countones(isr)) + 1)); // R9
  AST_EOI_SHRINKS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pulse && (isr != '0) && (ack_clr == '0))
      |=> ($countones(isr) == $past($countones(isr)) - 1)); // R12
  AST_TYPE_CARRIES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    type_drive |-> (dout[7:3] == base[7:3])); // R10
endmodule

bind pic8_ctrl pic8_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .ready(ready_w), .irr(irr_w),
  .mask(mask_w), .isr(isr_w), .init_pulse(init_w), .eoi_pulse(eoi_w),
  .ack_clr(ack_clr_w), .type_drive(drive_w), .dout(bus_rdata), .base(base_w)
);

// File: tb/pic8_ctrl_bench.sv
`timescale 1ns/1ps
module pic8_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0, ack_n = 1'b1;
  logic [7:0] wdata = 8'h00, irq = 8'h00, rdata;
  logic rdata_en, cpu_irq;
  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  pic8_ctrl u_pic8_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(sel_n), .bus_rd_n(rd_n),
    .bus_wr_n(wr_n), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .bus_rdata_en(rdata_en), .irq_in(irq), .cpu_irq(cpu_irq), .ack_n(ack_n)
  );

  // Behavioural reference model
  int m_st = 0;
  bit m_level, m_solo, m_ext, m_wrq, m_akq, m_phase, m_sec;
  logic [7:0] m_base = 0, m_imr = 8'hFF, m_irr = 0, m_isr = 0, m_prev = 8'hFF;
  int m_vec = 0;

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit model_int();
    return (m_st == 4) && (lowest(m_irr & ~m_imr) < lowest(m_isr));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_base = 0; m_imr = 8'hFF; m_irr = 0; m_isr = 0; m_prev = 8'hFF;
      m_wrq = 0; m_akq = 0; m_phase = 0; m_sec = 0; m_vec = 0;
      m_level = 0; m_solo = 0; m_ext = 0;
    end else begin
      bit wf, af, go;
      logic [7:0] n_irr, n_isr, clr;
      wf = !sel_n && !wr_n && !m_wrq;  m_wrq = !sel_n && !wr_n;
      af = !ack_n && !m_akq;           m_akq = !ack_n;
      go = model_int();
      n_isr = m_isr; clr = 0;
      if (af) begin
        if (!m_phase) begin
          m_phase = 1;
          if (go) begin
            m_vec = lowest(m_irr & ~m_imr);
            n_isr[m_vec] = 1'b1; clr[m_vec] = 1'b1;
          end else m_vec = 7;
        end else begin
          m_phase = 0; m_sec = 1;
        end
      end else if (ack_n) m_sec = 0;
      for (int i = 0; i < 8; i++)
        if (m_level) n_irr[i] = irq[i] && !clr[i];
        else n_irr[i] = (m_irr[i] || (irq[i] && !m_prev[i])) && irq[i] && !clr[i];
      m_prev = irq;
      if (wf) begin
        if (!addr && wdata[4]) begin
          m_level = wdata[3]; m_solo = wdata[1]; m_ext = wdata[0];
          m_imr = 0; n_irr = 0; n_isr = 0; m_prev = 8'hFF;
          m_phase = 0; m_sec = 0; m_st = 1;
        end else if (addr) begin
          case (m_st)
            1: begin m_base = wdata & 8'hF8; m_st = !m_solo ? 2 : (m_ext ? 3 : 4); end
            2: m_st = m_ext ? 3 : 4;
            3: m_st = 4;
            4: m_imr = wdata;
            default: ;
          endcase
        end else if (wdata == 8'h20 && m_st == 4 && m_isr != 0) begin
          n_isr[lowest(m_isr)] = 1'b0;
        end
      end
      m_irr = n_irr; m_isr = n_isr;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit e_int, e_en;
      logic [7:0] e_d;
      e_int = model_int();
      e_en  = (m_sec && !ack_n) || (!sel_n && !rd_n);
      if (m_sec && !ack_n) e_d = (m_base & 8'hF8) | 8'(m_vec);
      else if (!sel_n && !rd_n) e_d = addr ? m_imr : m_irr;
      else e_d = 8'h00;
      checks++;
      if (cpu_irq !== e_int || rdata_en !== e_en || rdata !== e_d) begin
        fails++;
        $display("FAIL %s model: irq=%b en=%b data=%h expected irq=%b en=%b data=%h",
                 cur_req, cpu_irq, rdata_en, rdata, e_int, e_en, e_d);
      end
    end
  end

  task automatic wr(input bit a, input logic [7:0] d, input int hold = 1);
    @(negedge clk); sel_n = 0; wr_n = 0; addr = a; wdata = d;
    repeat (hold) @(negedge clk);
    wr_n = 1; sel_n = 1;
    @(negedge clk);
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic chk_int(input bit e, input string tag);
    @(negedge clk); #1;
    checks++;
    if (cpu_irq !== e) begin
      fails++; $display("FAIL %s cpu_irq: actual %b expected %b", tag, cpu_irq, e);
    end
  endtask

  task automatic rd_chk(input bit a, input logic [7:0] e, input string tag);
    @(negedge clk); sel_n = 0; rd_n = 0; addr = a; #1;
    checks++;
    if (rdata !== e || rdata_en !== 1'b1) begin
      fails++; $display("FAIL %s read: actual %h expected %h", tag, rdata, e);
    end
    @(negedge clk); sel_n = 1; rd_n = 1;
  endtask

  task automatic ack_chk(input logic [7:0] e, input string tag);
    @(negedge clk); ack_n = 0;
    @(negedge clk); ack_n = 1;
    @(negedge clk); ack_n = 0;
    @(negedge clk); #1;
    checks++;
    if (rdata !== e || rdata_en !== 1'b1) begin
      fails++; $display("FAIL %s type: actual %h expected %h", tag, rdata, e);
    end
    @(negedge clk); ack_n = 1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    chk_int(0, "R1");
    rd_chk(1, 8'hFF, "R1");
    rd_chk(0, 8'h00, "R1");

    cur_req = "R2";
    set_irq(8'h08);
    wr(0, 8'h13);
    wr(1, 8'h40);
    cur_req = "R3";
    chk_int(0, "R3");
    wr(1, 8'h01);
    rd_chk(1, 8'h00, "R2");
    rd_chk(0, 8'h00, "R2");
    cur_req = "R6";
    set_irq(8'h00);
    set_irq(8'h08);
    rd_chk(0, 8'h08, "R6");
    chk_int(1, "R8");

    cur_req = "R9";
    ack_chk(8'h43, "R10");
    rd_chk(0, 8'h00, "R9");
    chk_int(0, "R9");

    cur_req = "R8";
    set_irq(8'h28);
    chk_int(0, "R8");
    set_irq(8'h2A);
    chk_int(1, "R8");
    ack_chk(8'h41, "R10");
    chk_int(0, "R8");

    cur_req = "R12";
    wr(0, 8'h20);
    chk_int(0, "R12");
    wr(0, 8'h20);
    chk_int(1, "R12");
    wr(0, 8'h0A);
    chk_int(1, "R12");

    cur_req = "R4";
    wr(1, 8'h20);
    chk_int(0, "R4");
    rd_chk(1, 8'h20, "R5");
    wr(1, 8'h00);
    chk_int(1, "R4");
    ack_chk(8'h45, "R10");
    wr(0, 8'h20);

    cur_req = "R11";
    set_irq(8'h00);
    chk_int(0, "R11");
    ack_chk(8'h47, "R11");
    set_irq(8'h40);
    chk_int(1, "R11");
    ack_chk(8'h46, "R10");
    wr(0, 8'h20);

    cur_req = "R6";
    set_irq(8'h00);
    set_irq(8'h04);
    set_irq(8'h00);
    rd_chk(0, 8'h00, "R6");
    chk_int(0, "R6");

    cur_req = "R7";
    set_irq(8'h01);
    wr(0, 8'h1A);
    chk_int(0, "R3");
    wr(1, 8'h80);
    chk_int(1, "R7");
    rd_chk(0, 8'h01, "R7");
    ack_chk(8'h80, "R7");
    rd_chk(0, 8'h01, "R7");
    chk_int(0, "R7");
    set_irq(8'h00);
    rd_chk(0, 8'h00, "R7");
    wr(0, 8'h20);

    cur_req = "R3";
    wr(0, 8'h11);
    wr(1, 8'hC8);
    set_irq(8'h10);
    chk_int(0, "R3");
    wr(1, 8'h00);
    chk_int(0, "R3");
    wr(1, 8'h01);
    chk_int(1, "R3");
    ack_chk(8'hCC, "R3");
    wr(0, 8'h20);
    set_irq(8'h00);

    cur_req = "R13";
    @(negedge clk); sel_n = 1; wr_n = 0; addr = 1; wdata = 8'hFF;
    @(negedge clk); @(negedge clk); wr_n = 1;
    rd_chk(1, 8'h00, "R13");
    set_irq(8'h02);
    ack_chk(8'hC9, "R13");
    set_irq(8'h03);
    chk_int(1, "R8");
    ack_chk(8'hC8, "R13");
    wr(0, 8'h20, 3);
    set_irq(8'h07);
    chk_int(0, "R13");
    wr(0, 8'h20);
    chk_int(1, "R13");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule